// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits in front of a small file of protected 32-bit registers, such as the configuration registers of a real-time clock, on a simple memory-mapped bus. The bus has a byte address, a write strobe, write data, a read strobe and registered read data. Writes to the protected registers land only while two separate 32-bit key registers both hold their magic values. Storing any other value in either key locks the gate again at once. Writing zero to both keys is the normal way to lock after an update.

A status register carries a BUSY flag tied to a single-cycle tick from a 32.768 kHz time base. BUSY rises a fixed number of fast-clock cycles before each expected tick and falls when the tick arrives. While BUSY is high, protected writes are refused even if the gate is unlocked. Software polls BUSY until it reads clear, writes the first key and then the second key, and then updates protected registers in the quiet stretch that follows.

Top module: `regwp_gate`

## Requirements
- R1: After reset, the gate is locked. Both key registers, every protected register and the status register read as zero.
- R2: The key register at byte offset 0x6C and the key register at byte offset 0x70 accept any written value, and a later read returns exactly that value.
- R3: The gate is unlocked only while the register at 0x6C holds 0x83E70B13 and the register at 0x70 holds 0x95A4F1E0. While unlocked and not BUSY, a write to protected word n (byte offset 4·n, n < NPROT) is stored and can be read back.
- R4: While locked, a protected write changes nothing, and reads keep returning the earlier contents.
- R5: Writing a value other than its magic to either key locks the gate from the next cycle on. Writing zero to both keys also locks it, and later protected writes are dropped.
- R6: The status register is at byte offset 0x44. Bit 0 is BUSY and bits 31:1 always read zero.
- R7: BUSY goes high once TICK_PERIOD−BUSY_LEAD cycles have passed since the last sampled tick (or since reset). It goes low in the cycle after a tick is sampled.
- R8: A protected write presented while BUSY is high is dropped, even when the gate is unlocked.
- R9: A read strobe returns data with the read-valid flag one cycle later. Unmapped or misaligned addresses (addr[1:0] ≠ 0) read as zero and take no writes.
- R10: If the tick is late, BUSY stays high until a tick is sampled.

Key registers are written whether or not BUSY is high. Protected writes take effect on the clock edge where they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| slow_tick | input | 1 | One-cycle pulse from the 32.768 kHz time base, synchronous to clk |

## Verification
The bench writes only the first key and checks that the gate stays shut. A design that tested either key alone would let that write through. It then writes a magic value that is off by one bit into the second key. Here a design that latched "unlocked" on an event, instead of comparing the stored values, would stay open. It aims protected writes into the BUSY window while the gate is open, and it holds the tick back past its period to confirm that BUSY stays up. A design that cleared BUSY on a timeout would accept writes during a slow-domain update. Zeroing both keys, reading the status word's upper bits and reading misaligned addresses catch a lock that fails to close, stray status bits, and a decoder that ignores the low address bits.

// File: rtl/regwp_pkg.sv
package regwp_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = ADDR_W - WORD_LSB;

    localparam logic [ADDR_W-1:0] KEY_A_OFF = 8'h6C;
    localparam logic [ADDR_W-1:0] KEY_B_OFF = 8'h70;
    localparam logic [ADDR_W-1:0] STAT_OFF  = 8'h44;

    localparam logic [DATA_W-1:0] KEY_A_MAGIC = 32'h83E70B13;
    localparam logic [DATA_W-1:0] KEY_B_MAGIC = 32'h95A4F1E0;

    localparam int STAT_BUSY_BIT = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PROT,
        SEL_KEYA,
        SEL_KEYB,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        sel_e              sel;
        logic [WORD_W-1:0] word;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nprot);
        dec_t d;
        d.word = a[ADDR_W-1:WORD_LSB];
        d.sel  = SEL_NONE;
        if (a[WORD_LSB-1:0] == '0) begin
            if (a == KEY_A_OFF)            d.sel = SEL_KEYA;
            else if (a == KEY_B_OFF)       d.sel = SEL_KEYB;
            else if (a == STAT_OFF)        d.sel = SEL_STAT;
            else if (int'(d.word) < nprot) d.sel = SEL_PROT;
        end
        return d;
    endfunction

    function automatic logic pair_matches(input logic [DATA_W-1:0] ka,
                                          input logic [DATA_W-1:0] kb);
        return (ka == KEY_A_MAGIC) && (kb == KEY_B_MAGIC);
    endfunction

endpackage

// File: rtl/regwp_decode.sv
module regwp_decode
    import regwp_pkg::*;
#(
    parameter int NPROT = 4,
    localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_prot,
    output logic              wr_keya,
    output logic              wr_keyb
);
    dec_t d;

    always_comb begin
        d       = decode_addr(addr, NPROT);
        sel     = d.sel;
        idx     = d.word[IDX_W-1:0];
        wr_prot = wr && (d.sel == SEL_PROT);
        wr_keya = wr && (d.sel == SEL_KEYA);
        wr_keyb = wr && (d.sel == SEL_KEYB);
    end
endmodule

// File: rtl/regwp_keys.sv
module regwp_keys
    import regwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_keya,
    input  logic              wr_keyb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] key_a,
    output logic [DATA_W-1:0] key_b,
    output logic              unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key_a <= '0;
            key_b <= '0;
        end else begin
            if (wr_keya) key_a <= wdata;
            if (wr_keyb) key_b <= wdata;
        end
    end

    always_comb unlocked = pair_matches(key_a, key_b);
endmodule

// File: rtl/regwp_busy.sv
module regwp_busy #(
    parameter int TICK_PERIOD = 64,
    parameter int BUSY_LEAD   = 8,
    localparam int START = TICK_PERIOD - BUSY_LEAD,
    localparam int CNT_W = $clog2(START + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic busy
);
    logic [CNT_W-1:0] since_tick;

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            since_tick <= '0;
        end else if (since_tick != CNT_W'(START)) begin
            since_tick <= since_tick + 1'b1;
        end
    end

    always_comb busy = (since_tick == CNT_W'(START));
endmodule

// File: rtl/regwp_regs.sv
module regwp_regs
    import regwp_pkg::*;
#(
    parameter int NPROT = 4,
    localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NPROT-1:0][DATA_W-1:0] regs
);
    for (genvar g = 0; g < NPROT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/regwp_gate.sv
module regwp_gate
    import regwp_pkg::*;
#(
    parameter int NPROT       = 4,
    parameter int TICK_PERIOD = 64,
    parameter int BUSY_LEAD   = 8,
    localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              slow_tick
);
    sel_e                         sel;
    logic [IDX_W-1:0]             idx;
    logic                         wr_prot, wr_keya, wr_keyb;
    logic [DATA_W-1:0]            key_a, key_b;
    logic                         unlocked, busy, prot_we;
    logic [NPROT-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]            rdata_d;

    regwp_decode #(.NPROT(NPROT)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .sel(sel), .idx(idx),
        .wr_prot(wr_prot), .wr_keya(wr_keya), .wr_keyb(wr_keyb)
    );

    regwp_keys u_keys (
        .clk(clk), .rst(rst), .wr_keya(wr_keya), .wr_keyb(wr_keyb),
        .wdata(bus_wdata), .key_a(key_a), .key_b(key_b), .unlocked(unlocked)
    );

    regwp_busy #(.TICK_PERIOD(TICK_PERIOD), .BUSY_LEAD(BUSY_LEAD)) u_busy (
        .clk(clk), .rst(rst), .tick(slow_tick), .busy(busy)
    );

    always_comb prot_we = wr_prot && unlocked && !busy;

    regwp_regs #(.NPROT(NPROT)) u_regs (
        .clk(clk), .rst(rst), .we(prot_we), .widx(idx),
        .wdata(bus_wdata), .regs(regs)
    );

    always_comb begin
        rdata_d = '0;
        unique case (sel)
            SEL_PROT: rdata_d = regs[idx];
            SEL_KEYA: rdata_d = key_a;
            SEL_KEYB: rdata_d = key_b;
            SEL_STAT: rdata_d[STAT_BUSY_BIT] = busy;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rdata_d;
        end
    end
endmodule

// File: rtl/regwp_chk.sv
module regwp_chk
    import regwp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic        slow_tick,
    input logic        busy,
    input logic        unlocked,
    input logic        prot_we
);
    p_locked_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> !prot_we);

    p_busy_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !prot_we);

    p_bad_key_a_relock_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == KEY_A_OFF && bus_wdata != KEY_A_MAGIC) |=> !unlocked);

    p_bad_key_b_relock_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == KEY_B_OFF && bus_wdata != KEY_B_MAGIC) |=> !unlocked);

    p_status_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_OFF) |=> ((bus_rdata & ~32'h1) == 32'h0));

    p_busy_falls_r7: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !busy);

    p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !slow_tick) |=> busy);
endmodule

bind regwp_gate regwp_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .slow_tick(slow_tick), .busy(busy),
    .unlocked(unlocked), .prot_we(prot_we)
);

// File: tb/tb_regwp_gate.sv
module tb_regwp_gate;
    localparam int CLK_PERIOD = 10;
    localparam int TP    = 64;
    localparam int BL    = 8;
    localparam int START = TP - BL;
    localparam int NP    = 4;
    localparam logic [31:0] MA = 32'h83E70B13;
    localparam logic [31:0] MB = 32'h95A4F1E0;

    logic        clk = 0, rst = 1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0, slow_tick = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0, fails = 0;
    int since = 0;
    int tick_ctr = 0;
    bit hold_tick = 0;

    logic [31:0] m_regs [NP];
    logic [31:0] m_ka, m_kb;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    regwp_gate #(.NPROT(NP), .TICK_PERIOD(TP), .BUSY_LEAD(BL)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .slow_tick(slow_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model of elapsed cycles since the last sampled tick
    always @(posedge clk) begin
        if (rst || slow_tick) since <= 0;
        else since <= since + 1;
    end

    // tick source
    always @(negedge clk) begin
        if (rst || hold_tick) begin
            slow_tick <= 0;
        end else if (tick_ctr == TP - 1) begin
            slow_tick <= 1;
            tick_ctr  <= 0;
        end else begin
            slow_tick <= 0;
            tick_ctr  <= tick_ctr + 1;
        end
    end

    function automatic bit m_busy();
        return since >= START;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        if (a == 8'h6C) m_ka = d;
        else if (a == 8'h70) m_kb = d;
        else if (a[1:0] == 0 && int'(a[7:2]) < NP && m_ka == MA && m_kb == MB && !m_busy())
            m_regs[a[7:2]] = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        if (a == 8'h6C) e = m_ka;
        else if (a == 8'h70) e = m_kb;
        else if (a == 8'h44) e = {31'b0, m_busy()};
        else if (a[1:0] == 0 && int'(a[7:2]) < NP) e = m_regs[a[7:2]];
        else e = 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_free();
        do @(negedge clk); while (!(since < START - 6));
    endtask

    task automatic wait_busy();
        do @(negedge clk); while (!(since >= START && since <= TP - 4));
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (R1..all) actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        foreach (m_regs[i]) m_regs[i] = '0;
        m_ka = '0; m_kb = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk(bus_rvalid === 1'b0, "R1 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
        // R1 reset state
        rd(8'h6C, "R1 key A reset");
        rd(8'h70, "R1 key B reset");
        rd(8'h44, "R1 status reset");
        rd(8'h00, "R1 prot0 reset");
        // R4 locked write dropped
        wait_free();
        wr(8'h04, 32'hDEAD0001);
        rd(8'h04, "R4 locked write dropped");
        // only first key: still locked
        wr(8'h6C, MA);
        rd(8'h6C, "R2 key A readback");
        wait_free();
        wr(8'h08, 32'h11112222);
        rd(8'h08, "R3 one key is not enough");
        // both keys: unlocked
        wr(8'h70, MB);
        wait_free();
        for (int i = 0; i < NP; i++) wr(8'(i * 4), 32'hA5A50000 + i);
        for (int i = 0; i < NP; i++) rd(8'(i * 4), "R3 unlocked write stored");
        // R8 write during busy dropped; R7 status busy
        wait_busy();
        rd(8'h44, "R7 status shows busy");
        wait_busy();
        wr(8'h00, 32'hBADBAD00);
        rd(8'h00, "R8 busy write dropped");
        wait_free();
        rd(8'h44, "R7 busy clear after tick");
        // R5 near-miss key relocks
        wr(8'h70, MB ^ 32'h1);
        rd(8'h70, "R2 key B readback");
        wait_free();
        wr(8'h0C, 32'h0C0C0C0C);
        rd(8'h0C, "R5 bad key relocks");
        // restore then zero both
        wr(8'h70, MB);
        wait_free();
        wr(8'h0C, 32'h77778888);
        rd(8'h0C, "R3 reunlocked write");
        wr(8'h6C, 32'h0);
        wr(8'h70, 32'h0);
        wait_free();
        wr(8'h0C, 32'h99990000);
        rd(8'h0C, "R5 zero keys relock");
        // R9 unmapped / misaligned
        rd(8'h40, "R9 unmapped reads zero");
        rd(8'h6D, "R9 misaligned reads zero");
        rd(8'h46, "R6 status misaligned zero");
        // R10 late tick keeps busy high
        wait_free();
        hold_tick = 1;
        repeat (TP + 20) @(negedge clk);
        rd(8'h44, "R10 busy held while tick late");
        hold_tick = 0;
        wait_free();
        rd(8'h44, "R10 busy falls after tick");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads answered", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule